// File: doc/BRIEF.md
# Stallable completion and commit stage

This block is the completion and writeback control that sits behind a multi-cycle execution unit in an in-order pipeline. An issuing stage hands it one instruction at a time: a destination register index, a tag, record and compare flags, and a condition field number. The unit's sequencer then signals the cycle in which the instruction is finished. On that cycle the block copies everything that writeback needs into registers of its own, so the sequencer can return to idle and take the next instruction while the completion is still waiting.

The block issues the completion only in a cycle where the downstream second-stage stall input is low. Because of this, the writeback of one instruction can appear while the following instruction is already executing. The block keeps two copies of the unit's status word, a working copy and a committed copy. Each completion or interrupt advances the committed copy. A pipeline flush that this block did not cause itself reloads the working copy from the committed one.

The block also drives a busy flag and a second-stage stall output toward the issuing stage. It raises an interrupt request for illegal operations, and for enabled exceptions found in the status word.

Top module: `xuc_complete_ctl`

## Requirements
- R1: After reset, busy, s2_stall, wb_valid, wb_reg_we, wb_cr_we and intr_req are 0, and status_o and commit_o are both zero.
- R2: An accepted issue_valid while idle sets busy from the next cycle. Each later cycle in which the instruction runs without finishing, with ds_stall low, sets s2_stall from the next cycle. A cycle with ds_stall high leaves s2_stall unchanged. A seq_done cycle clears both busy and s2_stall from the next cycle.
- R3: A seq_done cycle with ds_stall low gives wb_valid high for exactly the one following cycle.
- R4: While ds_stall is high, a finished instruction's wb_valid and intr_req are held back. They appear in the cycle after the first cycle with ds_stall low.
- R5: wb_tag, wb_reg_idx, wb_cr_mask and wb_cr_data belong to the completing instruction, even when a later instruction has already been issued.
- R6: wb_reg_we is high only together with wb_valid, and only when seq_wr was high on the done cycle of an instruction that was not illegal.
- R7: wb_cr_we is high with wb_valid when the instruction had record or compare set. With field 0 at the mask MSB, field f is mask bit 7−f. A non-compare uses field 1 (0x40) and a compare uses issue_crf. wb_cr_data is the 4-bit result repeated eight times. The result is seq_cr for a compare; in record mode it is status bits 31..28, taking any status write made in the done cycle.
- R8: An illegal instruction (seq_illegal on its done cycle) gives no wb_valid and no register write. Instead it gives intr_req for one cycle.
- R9: A completion in which status bit 30 is set and exc_en is high gives intr_req together with wb_valid.
- R10: In the cycle after wb_valid or intr_req, commit_o equals the status_o value that was present during that pulse.
- R11: A flush clears busy, s2_stall, pending completions, wb_valid and intr_req from the next cycle, and commit_o is unchanged. When intr_req is low, status_o is reloaded from commit_o. When intr_req is high, status_o is kept.
- R12: st_we with st_wdata replaces status_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Pipeline flush |
| issue_valid | input | 1 | New instruction from the issuing stage |
| issue_idx | input | IDX_W | Destination register index |
| issue_tag | input | TAG_W | Instruction tag |
| issue_rec | input | 1 | Record mode: write the condition field from the status |
| issue_cmp | input | 1 | Compare: write the condition field from seq_cr |
| issue_crf | input | CRF_W | Target condition field for compares |
| seq_done | input | 1 | Sequencer reports the running instruction finished |
| seq_wr | input | 1 | Finished instruction writes its register |
| seq_illegal | input | 1 | Finished instruction is illegal |
| seq_cr | input | 4 | Compare result nibble |
| st_we | input | 1 | Working status write enable |
| st_wdata | input | STATUS_W | Working status write data |
| exc_en | input | 1 | Exception interrupts enabled |
| ds_stall | input | 1 | Downstream second-stage stall |
| busy | output | 1 | Unit is executing an instruction |
| s2_stall | output | 1 | Second-stage stall toward the issuing stage |
| wb_valid | output | 1 | Completion pulse |
| wb_tag | output | TAG_W | Tag of the completing instruction |
| wb_reg_we | output | 1 | Register write enable |
| wb_reg_idx | output | IDX_W | Register index for the write |
| wb_cr_we | output | 1 | Condition write enable |
| wb_cr_mask | output | CR_FIELDS | Condition field select |
| wb_cr_data | output | 4*CR_FIELDS | Replicated condition result |
| intr_req | output | 1 | Interrupt request pulse |
| status_o | output | STATUS_W | Working status word |
| commit_o | output | STATUS_W | Committed status word |

## Verification
The writeback pulse, its fields and intr_req are registered. They are due one edge after the done cycle, or one edge after the first stall-free cycle when ds_stall is high. The bench samples them two time units after that edge and checks that they are gone one cycle later. busy, s2_stall and status_o follow their triggering input by one edge. commit_o is checked one cycle after the writeback or interrupt pulse. A flush is checked at the edge it takes effect. A random stream of stalls and slipped completions is checked at each falling edge against a queue of issued tags, so that each tag must appear once, in order, with its own index and mask.

// File: rtl/xuc_pkg.sv
package xuc_pkg;
   // Width of one condition field result.
   localparam int unsigned CRN_W = 4;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/xuc_issue_track.sv
module xuc_issue_track
   import xuc_pkg::*;
#(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned CRF_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush,
   input  logic             issue_valid,
   input  logic [IDX_W-1:0] issue_idx,
   input  logic [TAG_W-1:0] issue_tag,
   input  logic             issue_rec,
   input  logic             issue_cmp,
   input  logic [CRF_W-1:0] issue_crf,
   input  logic             seq_done,
   input  logic             ds_stall,
   output logic             busy,
   output logic             s2_stall,
   output logic             done_evt,
   output logic [IDX_W-1:0] cur_idx,
   output logic [TAG_W-1:0] cur_tag,
   output logic             cur_rec,
   output logic             cur_cmp,
   output logic [CRF_W-1:0] cur_crf
);
   seq_state_e st_q;
   logic       busy_q, s2_q;

   assign done_evt = (st_q == ST_RUN) && seq_done;

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         st_q   <= ST_IDLE;
         busy_q <= 1'b0;
         s2_q   <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         if (issue_valid) begin
            st_q   <= ST_RUN;
            busy_q <= 1'b1;
         end
      end else if (seq_done) begin
         st_q   <= ST_IDLE;
         busy_q <= 1'b0;
         s2_q   <= 1'b0;
      end else if (!ds_stall) begin
         s2_q   <= 1'b1;
      end
   end

   // Working copy of the running instruction; overwritten only on issue.
   always_ff @(posedge clk) begin
      if (rst) begin
         cur_idx <= '0;
         cur_tag <= '0;
         cur_rec <= 1'b0;
         cur_cmp <= 1'b0;
         cur_crf <= '0;
      end else if (st_q == ST_IDLE && issue_valid && !flush) begin
         cur_idx <= issue_idx;
         cur_tag <= issue_tag;
         cur_rec <= issue_rec;
         cur_cmp <= issue_cmp;
         cur_crf <= issue_crf;
      end
   end

   assign busy     = busy_q;
   assign s2_stall = s2_q;
endmodule

// File: rtl/xuc_status_commit.sv
module xuc_status_commit #(
   parameter int unsigned STATUS_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                flush,
   input  logic                own_intr,
   input  logic                commit_evt,
   input  logic                st_we,
   input  logic [STATUS_W-1:0] st_wdata,
   output logic [STATUS_W-1:0] work_next,
   output logic [STATUS_W-1:0] work,
   output logic [STATUS_W-1:0] comm
);
   assign work_next = st_we ? st_wdata : work;

   always_ff @(posedge clk) begin
      if (rst) begin
         work <= '0;
         comm <= '0;
      end else if (flush) begin
         if (!own_intr) begin
            work <= comm;
         end
      end else begin
         work <= work_next;
         if (commit_evt) begin
            comm <= work;
         end
      end
   end
endmodule

// File: rtl/xuc_done_latch.sv
module xuc_done_latch
   import xuc_pkg::*;
#(
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned TAG_W      = 6,
   parameter int unsigned CRF_W      = 3,
   parameter int unsigned CR_FIELDS  = 8,
   parameter bit          FIELD0_MSB = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 flush,
   input  logic                 done_evt,
   input  logic                 seq_wr,
   input  logic                 seq_illegal,
   input  logic [CRN_W-1:0]     seq_cr,
   input  logic [IDX_W-1:0]     cur_idx,
   input  logic [TAG_W-1:0]     cur_tag,
   input  logic                 cur_rec,
   input  logic                 cur_cmp,
   input  logic [CRF_W-1:0]     cur_crf,
   input  logic                 ds_stall,
   input  logic                 exc_en,
   input  logic                 exc_next,
   input  logic [CRN_W-1:0]     rec_nib,
   output logic                 cmpl,
   output logic                 intr,
   output logic                 wr_reg,
   output logic                 wr_cr,
   output logic [IDX_W-1:0]     lat_idx,
   output logic [TAG_W-1:0]     lat_tag,
   output logic [CR_FIELDS-1:0] lat_mask,
   output logic [CRN_W-1:0]     lat_cr
);
   localparam logic [CR_FIELDS-1:0] ONE_LSB = CR_FIELDS'(1);
   localparam logic [CR_FIELDS-1:0] ONE_MSB = ONE_LSB << (CR_FIELDS - 1);

   logic [CR_FIELDS-1:0] cmp_mask, dflt_mask;

   generate
      if (FIELD0_MSB) begin : g_msb_first
         assign cmp_mask  = ONE_MSB >> cur_crf;
         assign dflt_mask = ONE_MSB >> 1;
      end else begin : g_lsb_first
         assign cmp_mask  = ONE_LSB << cur_crf;
         assign dflt_mask = ONE_LSB << 1;
      end
   endgenerate

   logic                 pend_q, ill_q;
   logic                 pend_d, ill_d, wr_reg_d, wr_cr_d, cmpl_d, intr_d;
   logic [IDX_W-1:0]     idx_d;
   logic [TAG_W-1:0]     tag_d;
   logic [CR_FIELDS-1:0] mask_d;
   logic [CRN_W-1:0]     cr_d;

   always_comb begin
      pend_d   = pend_q;
      ill_d    = ill_q;
      wr_reg_d = wr_reg;
      wr_cr_d  = wr_cr;
      idx_d    = lat_idx;
      tag_d    = lat_tag;
      mask_d   = lat_mask;
      cr_d     = lat_cr;
      cmpl_d   = 1'b0;
      intr_d   = 1'b0;
      // A completion or interrupt issued last cycle retires the record.
      if (cmpl || intr) begin
         pend_d   = 1'b0;
         ill_d    = 1'b0;
         wr_reg_d = 1'b0;
         wr_cr_d  = 1'b0;
      end
      if (done_evt) begin
         pend_d   = 1'b1;
         ill_d    = seq_illegal;
         wr_reg_d = seq_wr && !seq_illegal;
         wr_cr_d  = cur_rec || cur_cmp;
         idx_d    = cur_idx;
         tag_d    = cur_tag;
         mask_d   = cur_cmp ? cmp_mask : dflt_mask;
         cr_d     = cur_rec ? rec_nib : seq_cr;
      end
      if (pend_d && !ds_stall) begin
         cmpl_d = !ill_d;
         intr_d = (exc_next && exc_en) || ill_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         pend_q   <= 1'b0;
         ill_q    <= 1'b0;
         wr_reg   <= 1'b0;
         wr_cr    <= 1'b0;
         cmpl     <= 1'b0;
         intr     <= 1'b0;
         lat_idx  <= '0;
         lat_tag  <= '0;
         lat_mask <= '0;
         lat_cr   <= '0;
      end else begin
         pend_q   <= pend_d;
         ill_q    <= ill_d;
         wr_reg   <= wr_reg_d;
         wr_cr    <= wr_cr_d;
         cmpl     <= cmpl_d;
         intr     <= intr_d;
         lat_idx  <= idx_d;
         lat_tag  <= tag_d;
         lat_mask <= mask_d;
         lat_cr   <= cr_d;
      end
   end
endmodule

// File: rtl/xuc_complete_ctl.sv
module xuc_complete_ctl
   import xuc_pkg::*;
#(
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned TAG_W      = 6,
   parameter int unsigned CR_FIELDS  = 8,
   parameter int unsigned STATUS_W   = 32,
   parameter int unsigned EXC_BIT    = 30,
   parameter int unsigned REC_LSB    = 28,
   parameter bit          FIELD0_MSB = 1'b1,
   localparam int unsigned CRF_W     = $clog2(CR_FIELDS),
   localparam int unsigned CRD_W     = CRN_W * CR_FIELDS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 flush,
   input  logic                 issue_valid,
   input  logic [IDX_W-1:0]     issue_idx,
   input  logic [TAG_W-1:0]     issue_tag,
   input  logic                 issue_rec,
   input  logic                 issue_cmp,
   input  logic [CRF_W-1:0]     issue_crf,
   input  logic                 seq_done,
   input  logic                 seq_wr,
   input  logic                 seq_illegal,
   input  logic [CRN_W-1:0]     seq_cr,
   input  logic                 st_we,
   input  logic [STATUS_W-1:0]  st_wdata,
   input  logic                 exc_en,
   input  logic                 ds_stall,
   output logic                 busy,
   output logic                 s2_stall,
   output logic                 wb_valid,
   output logic [TAG_W-1:0]     wb_tag,
   output logic                 wb_reg_we,
   output logic [IDX_W-1:0]     wb_reg_idx,
   output logic                 wb_cr_we,
   output logic [CR_FIELDS-1:0] wb_cr_mask,
   output logic [CRD_W-1:0]     wb_cr_data,
   output logic                 intr_req,
   output logic [STATUS_W-1:0]  status_o,
   output logic [STATUS_W-1:0]  commit_o
);
   generate
      if (EXC_BIT >= STATUS_W) begin : g_bad_exc
         $error("EXC_BIT lies outside the status word");
      end
      if (REC_LSB + CRN_W > STATUS_W) begin : g_bad_rec
         $error("record nibble lies outside the status word");
      end
      if (CR_FIELDS < 2) begin : g_bad_fields
         $error("at least two condition fields are required");
      end
   endgenerate

   logic             done_evt, cur_rec, cur_cmp;
   logic [IDX_W-1:0] cur_idx;
   logic [TAG_W-1:0] cur_tag;
   logic [CRF_W-1:0] cur_crf;
   logic             cmpl, intr, wr_reg, wr_cr;
   logic [CRN_W-1:0] lat_cr;
   logic [STATUS_W-1:0] work_next;

   xuc_issue_track #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CRF_W(CRF_W)) trk_i (
      .clk(clk), .rst(rst), .flush(flush),
      .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_tag(issue_tag),
      .issue_rec(issue_rec), .issue_cmp(issue_cmp), .issue_crf(issue_crf),
      .seq_done(seq_done), .ds_stall(ds_stall),
      .busy(busy), .s2_stall(s2_stall), .done_evt(done_evt),
      .cur_idx(cur_idx), .cur_tag(cur_tag), .cur_rec(cur_rec),
      .cur_cmp(cur_cmp), .cur_crf(cur_crf)
   );

   xuc_status_commit #(.STATUS_W(STATUS_W)) st_i (
      .clk(clk), .rst(rst), .flush(flush),
      .own_intr(intr), .commit_evt(cmpl || intr),
      .st_we(st_we), .st_wdata(st_wdata),
      .work_next(work_next), .work(status_o), .comm(commit_o)
   );

   xuc_done_latch #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .CRF_W(CRF_W),
      .CR_FIELDS(CR_FIELDS), .FIELD0_MSB(FIELD0_MSB)
   ) lat_i (
      .clk(clk), .rst(rst), .flush(flush),
      .done_evt(done_evt), .seq_wr(seq_wr), .seq_illegal(seq_illegal),
      .seq_cr(seq_cr), .cur_idx(cur_idx), .cur_tag(cur_tag),
      .cur_rec(cur_rec), .cur_cmp(cur_cmp), .cur_crf(cur_crf),
      .ds_stall(ds_stall), .exc_en(exc_en),
      .exc_next(work_next[EXC_BIT]),
      .rec_nib(work_next[REC_LSB +: CRN_W]),
      .cmpl(cmpl), .intr(intr), .wr_reg(wr_reg), .wr_cr(wr_cr),
      .lat_idx(wb_reg_idx), .lat_tag(wb_tag), .lat_mask(wb_cr_mask),
      .lat_cr(lat_cr)
   );

   // Writeback reads only the latched record, never the working copy.
   assign wb_valid  = cmpl;
   assign wb_reg_we = wr_reg && cmpl;
   assign wb_cr_we  = wr_cr && cmpl;
   assign intr_req  = intr;

   generate
      for (genvar f = 0; f < CR_FIELDS; f++) begin : g_cr_rep
         assign wb_cr_data[f*CRN_W +: CRN_W] = lat_cr;
      end
   endgenerate
endmodule

// File: rtl/xuc_complete_chk.sv
module xuc_complete_chk #(
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned TAG_W     = 6,
   parameter int unsigned CR_FIELDS = 8,
   parameter int unsigned STATUS_W  = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                flush,
   input logic                issue_valid,
   input logic                ds_stall,
   input logic                busy,
   input logic                s2_stall,
   input logic                wb_valid,
   input logic                wb_reg_we,
   input logic                intr_req,
   input logic [STATUS_W-1:0] status_o,
   input logic [STATUS_W-1:0] commit_o
);
   // R4
   cmpl_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
      wb_valid |-> $past(!ds_stall));
   // R4
   intr_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
      intr_req |-> $past(!ds_stall));
   // R6
   regwe_in_cmpl_chk: assert property (@(posedge clk) disable iff (rst)
      wb_reg_we |-> wb_valid);
   // R2
   s2stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
      s2_stall |-> busy);
   // R11
   flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!busy && !wb_valid && !intr_req && !s2_stall));
   // R10
   commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
      ((wb_valid || intr_req) && !flush) |=> (commit_o == $past(status_o)));
   // R2
   no_issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> !busy);
   // R4
   no_issue_stall_chk: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> !ds_stall);
endmodule

bind xuc_complete_ctl xuc_complete_chk #(
   .IDX_W(IDX_W), .TAG_W(TAG_W), .CR_FIELDS(CR_FIELDS), .STATUS_W(STATUS_W)
) chk_i (
   .clk(clk), .rst(rst), .flush(flush), .issue_valid(issue_valid),
   .ds_stall(ds_stall), .busy(busy), .s2_stall(s2_stall),
   .wb_valid(wb_valid), .wb_reg_we(wb_reg_we), .intr_req(intr_req),
   .status_o(status_o), .commit_o(commit_o)
);

// File: tb/xuc_complete_ctl_tb_top.sv
module xuc_complete_ctl_tb_top;
   localparam int N_RND = 40;

   logic        clk = 1'b0;
   logic        rst, flush, issue_valid, issue_rec, issue_cmp;
   logic [5:0]  issue_idx, issue_tag;
   logic [2:0]  issue_crf;
   logic        seq_done, seq_wr, seq_illegal, st_we, exc_en, ds_stall;
   logic [3:0]  seq_cr;
   logic [31:0] st_wdata;
   logic        busy, s2_stall, wb_valid, wb_reg_we, wb_cr_we, intr_req;
   logic [5:0]  wb_tag, wb_reg_idx;
   logic [7:0]  wb_cr_mask;
   logic [31:0] wb_cr_data, status_o, commit_o;

   int vectors = 0;
   int miscompares = 0;
   bit sb_on = 1'b0;
   int sb_got = 0;
   logic [5:0] exp_tag [N_RND];
   logic [5:0] exp_idx [N_RND];
   logic [7:0] exp_mask[N_RND];

   always #5 clk = ~clk;

   xuc_complete_ctl dut_i (
      .clk(clk), .rst(rst), .flush(flush), .issue_valid(issue_valid),
      .issue_idx(issue_idx), .issue_tag(issue_tag), .issue_rec(issue_rec),
      .issue_cmp(issue_cmp), .issue_crf(issue_crf), .seq_done(seq_done),
      .seq_wr(seq_wr), .seq_illegal(seq_illegal), .seq_cr(seq_cr),
      .st_we(st_we), .st_wdata(st_wdata), .exc_en(exc_en), .ds_stall(ds_stall),
      .busy(busy), .s2_stall(s2_stall), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .wb_reg_we(wb_reg_we), .wb_reg_idx(wb_reg_idx), .wb_cr_we(wb_cr_we),
      .wb_cr_mask(wb_cr_mask), .wb_cr_data(wb_cr_data), .intr_req(intr_req),
      .status_o(status_o), .commit_o(commit_o)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // One clock; inputs change and outputs are read 2 ns after the edge.
   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic issue(input logic [5:0] idx, input logic [5:0] tag,
                        input logic rec, input logic cmp, input logic [2:0] crf);
      issue_valid = 1'b1; issue_idx = idx; issue_tag = tag;
      issue_rec = rec; issue_cmp = cmp; issue_crf = crf;
      cyc();
      issue_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; flush = 0; issue_valid = 0; issue_idx = 0; issue_tag = 0;
      issue_rec = 0; issue_cmp = 0; issue_crf = 0; seq_done = 0; seq_wr = 0;
      seq_illegal = 0; seq_cr = 0; st_we = 0; st_wdata = 0; exc_en = 0;
      ds_stall = 0;
      repeat (3) cyc();
      rst = 1'b0;
      chk("R1 busy", busy, 0);
      chk("R1 s2_stall", s2_stall, 0);
      chk("R1 wb_valid", wb_valid, 0);
      chk("R1 intr_req", intr_req, 0);
      chk("R1 wb_reg_we", wb_reg_we, 0);
      chk("R1 wb_cr_we", wb_cr_we, 0);
      chk("R1 status_o", status_o, 0);
      chk("R1 commit_o", commit_o, 0);
   endtask

   task automatic t_basic();
      issue(6'd5, 6'd3, 0, 0, 3'd0);
      chk("R2 busy after issue", busy, 1);
      chk("R2 s2_stall in first run cycle", s2_stall, 0);
      cyc();
      chk("R2 s2_stall while running", s2_stall, 1);
      seq_done = 1; seq_wr = 1;
      cyc();
      seq_done = 0; seq_wr = 0;
      chk("R3 wb_valid", wb_valid, 1);
      chk("R6 wb_reg_we", wb_reg_we, 1);
      chk("R5 wb_reg_idx", wb_reg_idx, 5);
      chk("R5 wb_tag", wb_tag, 3);
      chk("R7 default mask field 1", wb_cr_mask, 8'h40);
      chk("R7 wb_cr_we off", wb_cr_we, 0);
      chk("R2 busy after done", busy, 0);
      chk("R2 s2_stall after done", s2_stall, 0);
      cyc();
      chk("R3 single pulse", wb_valid, 0);
   endtask

   task automatic t_stall();
      issue(6'd9, 6'd10, 0, 0, 3'd0);
      ds_stall = 1; seq_done = 1; seq_wr = 1;
      cyc();
      seq_done = 0; seq_wr = 0;
      chk("R4 held under stall", wb_valid, 0);
      chk("R2 busy cleared under stall", busy, 0);
      repeat (2) cyc();
      chk("R4 still held", wb_valid, 0);
      ds_stall = 0;
      cyc();
      chk("R4 released", wb_valid, 1);
      chk("R4 tag", wb_tag, 10);
      chk("R6 we after stall", wb_reg_we, 1);
      cyc();
      chk("R4 single pulse", wb_valid, 0);
   endtask

   task automatic t_slip();
      issue(6'd17, 6'd20, 0, 0, 3'd0);
      ds_stall = 1; seq_done = 1; seq_wr = 1;
      cyc();
      seq_done = 0; seq_wr = 0;
      cyc();
      ds_stall = 0;
      issue(6'd33, 6'd21, 0, 1, 3'd2);
      chk("R5 slip valid", wb_valid, 1);
      chk("R5 slip old tag", wb_tag, 20);
      chk("R5 slip old idx", wb_reg_idx, 17);
      chk("R5 slip old mask", wb_cr_mask, 8'h40);
      chk("R2 new busy", busy, 1);
      seq_done = 1; seq_wr = 1; seq_cr = 4'h3;
      cyc();
      seq_done = 0; seq_wr = 0;
      chk("R5 next valid", wb_valid, 1);
      chk("R5 next tag", wb_tag, 21);
      chk("R5 next idx", wb_reg_idx, 33);
      chk("R7 next mask field 2", wb_cr_mask, 8'h20);
      cyc();
   endtask

   task automatic t_cmp();
      issue(6'd4, 6'd30, 0, 1, 3'd3);
      seq_done = 1; seq_wr = 0; seq_cr = 4'h5;
      cyc();
      seq_done = 0;
      chk("R7 cmp mask field 3", wb_cr_mask, 8'h10);
      chk("R7 cmp cr_we", wb_cr_we, 1);
      chk("R7 cmp cr data", wb_cr_data, 32'h5555_5555);
      chk("R6 no reg write", wb_reg_we, 0);
      cyc();
   endtask

   task automatic t_rec();
      issue(6'd7, 6'd31, 1, 0, 3'd0);
      st_we = 1; st_wdata = 32'h9000_00A5;
      cyc();
      st_we = 0;
      chk("R12 status write", status_o, 32'h9000_00A5);
      seq_done = 1; seq_wr = 1; seq_cr = 4'h0;
      cyc();
      seq_done = 0; seq_wr = 0;
      chk("R7 rec cr_we", wb_cr_we, 1);
      chk("R7 rec cr data", wb_cr_data, 32'h9999_9999);
      chk("R7 rec mask", wb_cr_mask, 8'h40);
      chk("R9 no intr", intr_req, 0);
      cyc();
      chk("R10 commit after complete", commit_o, 32'h9000_00A5);
   endtask

   task automatic t_illegal();
      st_we = 1; st_wdata = 32'h0000_1234;
      issue(6'd2, 6'd40, 0, 0, 3'd0);
      st_we = 0;
      seq_done = 1; seq_wr = 1; seq_illegal = 1;
      cyc();
      seq_done = 0; seq_wr = 0; seq_illegal = 0;
      chk("R8 no wb_valid", wb_valid, 0);
      chk("R8 intr", intr_req, 1);
      chk("R6 no reg we on illegal", wb_reg_we, 0);
      cyc();
      chk("R8 intr single", intr_req, 0);
      chk("R10 commit after intr", commit_o, 32'h0000_1234);
   endtask

   task automatic t_exc_own_flush();
      exc_en = 1;
      issue(6'd11, 6'd41, 0, 0, 3'd0);
      st_we = 1; st_wdata = 32'h4000_0001;
      ds_stall = 1; seq_done = 1;
      cyc();
      st_we = 0; seq_done = 0;
      chk("R4 intr held", intr_req, 0);
      ds_stall = 0;
      cyc();
      chk("R9 complete with exc", wb_valid, 1);
      chk("R9 intr with exc", intr_req, 1);
      flush = 1;
      cyc();
      flush = 0; exc_en = 0;
      chk("R11 own intr keeps status", status_o, 32'h4000_0001);
      chk("R11 commit unchanged", commit_o, 32'h0000_1234);
      chk("R11 intr cleared", intr_req, 0);
   endtask

   task automatic t_flush();
      issue(6'd12, 6'd42, 0, 0, 3'd0);
      cyc();
      flush = 1;
      cyc();
      flush = 0;
      chk("R11 rollback", status_o, 32'h0000_1234);
      chk("R11 busy cleared", busy, 0);
      chk("R11 s2 cleared", s2_stall, 0);
      seq_done = 1; seq_wr = 1;
      cyc();
      seq_done = 0; seq_wr = 0;
      chk("R11 nothing completes", wb_valid, 0);
      chk("R11 no reg we", wb_reg_we, 0);
   endtask

   task automatic t_s2hold();
      issue(6'd13, 6'd43, 0, 0, 3'd0);
      ds_stall = 1;
      repeat (2) cyc();
      chk("R2 s2 stays low under stall", s2_stall, 0);
      ds_stall = 0;
      cyc();
      chk("R2 s2 rises", s2_stall, 1);
      ds_stall = 1;
      cyc();
      chk("R2 s2 held under stall", s2_stall, 1);
      ds_stall = 0; seq_done = 1;
      cyc();
      seq_done = 0;
      chk("R2 s2 cleared on done", s2_stall, 0);
      cyc();
   endtask

   // Random stream; completions checked by the monitor below (R3, R4, R5).
   always @(negedge clk) begin
      if (sb_on && wb_valid) begin
         if (sb_got < N_RND) begin
            chk("R5 stream tag", wb_tag, exp_tag[sb_got]);
            chk("R5 stream idx", wb_reg_idx, exp_idx[sb_got]);
            chk("R7 stream mask", wb_cr_mask, exp_mask[sb_got]);
         end else begin
            chk("R3 extra completion", 1, 0);
         end
         sb_got++;
      end
   end

   task automatic t_stream();
      sb_on = 1;
      for (int i = 0; i < N_RND; i++) begin
         logic [5:0] idx;
         logic       cmp;
         logic [2:0] crf;
         idx = 6'($urandom_range(63));
         cmp = 1'($urandom_range(1));
         crf = 3'($urandom_range(7));
         exp_tag[i]  = 6'(i);
         exp_idx[i]  = idx;
         exp_mask[i] = cmp ? (8'h80 >> crf) : 8'h40;
         ds_stall = 0;
         issue(idx, 6'(i), 0, cmp, crf);
         repeat ($urandom_range(2)) begin
            ds_stall = 1'($urandom_range(1));
            cyc();
         end
         ds_stall = 1'($urandom_range(1));
         seq_done = 1; seq_wr = 1;
         cyc();
         seq_done = 0; seq_wr = 0;
         repeat ($urandom_range(2)) begin
            ds_stall = 1'($urandom_range(1));
            cyc();
         end
      end
      ds_stall = 0;
      repeat (3) cyc();
      sb_on = 0;
      chk("R3 each tag completes once", sb_got, N_RND);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_stall();
      t_slip();
      t_cmp();
      t_rec();
      t_illegal();
      t_exc_own_flush();
      t_flush();
      t_s2hold();
      t_stream();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule